// File: doc/BRIEF.md
# Peak-Centred Strip Cluster Finder

This block reads a stream of detector strip words from an input FIFO and groups neighbouring strips into clusters that are centred on their largest value. Each input word carries an 8-bit corrected pulse value, a 2-bit data type, an 11-bit strip address (chip number joined to strip number) and an end-of-event marker flag. A cluster is held in a row of five value slots. The third slot always holds the peak. Two shadow registers keep the most recent strips, so that a later and larger peak can move the centre without any strip being read again.

When a word arrives that cannot extend the open cluster, the cluster closes. If its peak reaches the peak threshold, the block presents the five slot values, the address one below the peak, a five-strip flag, the number of occupied slots and the number of strips that joined. It holds these on a valid/ready output until the consumer takes them. Both thresholds are plain inputs.

Top module: `scf_cluster_finder`

## Requirements
- R1: A strip joins the open cluster only if it is not an end marker, its value is at least `th_join`, its type equals the cluster's type, and its address equals the last joined address plus one (modulo 2^11). A gap in address, a type change or a low value closes the cluster.
- R2: With no cluster open, a non-marker word whose value is at least `th_join` starts a cluster. Its value goes into slot 3 (the peak), and slots 1, 2, 4 and 5 start empty with value zero.
- R3: A joining strip whose value is below the peak fills slot 4 and then slot 5. Once slot 5 is occupied, further such strips change no slot and only update the shadow history.
- R4: A joining strip whose value is greater than or equal to the peak becomes the new peak in slot 3. Slots 1 and 2 take the two strips that joined just before it, oldest in slot 1, and are zero and empty where fewer than two exist. Slots 4 and 5 are cleared and refill as in R3.
- R5: A closing cluster is presented at the output only if its peak value is at least `th_peak`. Otherwise it is dropped and `out_valid` stays low.
- R6: The word that closes a cluster is not consumed on that cycle. After the cluster is emitted or dropped, the word is evaluated again with no cluster open, so it can start the next cluster. An end marker closes a cluster in the same way and is then discarded.
- R7: `out_addr` is the peak strip's address minus one, modulo 2^11.
- R8: `out_five` is 1 when slots 1 and 5 are both occupied. `out_used` is the number of occupied slots. `out_checked` is the number of strips that joined the cluster, counting the first, and saturates at 255.
- R9: While `out_valid` is high and `out_ready` is low, all output fields hold steady. `in_ready` is low whenever `out_valid` is high.
- R10: With no cluster open, words below `th_join` and end markers are consumed and discarded.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: `out_vals` packs slot k (k = 1..5) in bits [8k-1 : 8k-8], so slot 1 sits in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| th_join | input | 8 | Minimum strip value for joining a cluster |
| th_peak | input | 8 | Minimum peak value for a cluster to be emitted |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word consumed on this edge |
| in_end | input | 1 | Word is an end-of-event marker |
| in_val | input | 8 | Corrected strip value |
| in_type | input | 2 | Strip data type |
| in_addr | input | 11 | Strip address |
| out_valid | output | 1 | Cluster result present |
| out_ready | input | 1 | Consumer takes the result |
| out_vals | output | 40 | Five slot values, slot 1 in the low byte |
| out_addr | output | 11 | Peak address minus one |
| out_five | output | 1 | Five-strip cluster flag |
| out_used | output | 3 | Occupied slot count |
| out_checked | output | 8 | Joined strip count, saturating |

## Verification
On every cycle, the assertions check that a held result stays stable and that the input is stalled while a result is pending. They also check that every emitted peak reaches the peak threshold, that no slot after the peak reaches it while slots before it never exceed it, and that the occupancy counts agree with the five-strip flag. Only the bench's scenarios can show that the right strips land in the right slots after a re-centring, and that a terminating word really starts the next cluster. The same holds for address wrap, counter saturation and silent dropping, which the bench compares against an arithmetic model over swept thresholds, streams and output back-pressure.

// File: rtl/scf_pkg.sv
package scf_pkg;
  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_OUT  = 1'b1
  } scf_state_e;
endpackage

// File: rtl/scf_join_check.sv
module scf_join_check #(
  parameter int VAL_W  = 8,
  parameter int TYPE_W = 2,
  parameter int ADDR_W = 11
) (
  input  logic              active,
  input  logic              in_end,
  input  logic [VAL_W-1:0]  in_val,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TYPE_W-1:0] cl_type,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [VAL_W-1:0]  th_join,
  output logic              above_th,
  output logic              joins
);
  logic [ADDR_W-1:0] next_addr;

  assign next_addr = last_addr + 1'b1;
  assign above_th  = !in_end && (in_val >= th_join);
  assign joins     = active && above_th && (in_type == cl_type) && (in_addr == next_addr);
endmodule

// File: rtl/scf_slots.sv
module scf_slots #(
  parameter int VAL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int SLOTS  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   start,
  input  logic                   accept,
  input  logic [VAL_W-1:0]       val,
  input  logic [ADDR_W-1:0]      addr,
  output logic [VAL_W-1:0]       peak_val,
  output logic [ADDR_W-1:0]      peak_addr,
  output logic [SLOTS*VAL_W-1:0] slot_flat,
  output logic [SLOTS-1:0]       occ
);
  localparam int PEAK   = SLOTS / 2;
  localparam int FILL_W = $clog2(SLOTS + 1);

  logic [VAL_W-1:0]  dat  [SLOTS];
  logic [VAL_W-1:0]  hist [PEAK];
  logic [PEAK-1:0]   hocc;
  logic [FILL_W-1:0] fill;
  logic              recentre;

  assign recentre = val >= dat[PEAK];
  assign peak_val = dat[PEAK];

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign slot_flat[g*VAL_W +: VAL_W] = dat[g];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < SLOTS; k++) dat[k] <= '0;
      for (int k = 0; k < PEAK; k++) hist[k] <= '0;
      occ       <= '0;
      hocc      <= '0;
      fill      <= '0;
      peak_addr <= '0;
    end else if (start) begin
      for (int k = 0; k < SLOTS; k++) dat[k] <= '0;
      for (int k = 0; k < PEAK; k++) hist[k] <= '0;
      occ             <= '0;
      hocc            <= '0;
      dat[PEAK]       <= val;
      occ[PEAK]       <= 1'b1;
      hist[PEAK-1]    <= val;
      hocc[PEAK-1]    <= 1'b1;
      fill            <= FILL_W'(PEAK + 1);
      peak_addr       <= addr;
    end else if (accept) begin
      if (recentre) begin
        for (int k = 0; k < PEAK; k++) begin
          dat[k] <= hist[k];
          occ[k] <= hocc[k];
        end
        dat[PEAK] <= val;
        for (int k = PEAK + 1; k < SLOTS; k++) begin
          dat[k] <= '0;
          occ[k] <= 1'b0;
        end
        fill      <= FILL_W'(PEAK + 1);
        peak_addr <= addr;
      end else if (fill < FILL_W'(SLOTS)) begin
        for (int k = PEAK + 1; k < SLOTS; k++) begin
          if (FILL_W'(k) == fill) begin
            dat[k] <= val;
            occ[k] <= 1'b1;
          end
        end
        fill <= fill + 1'b1;
      end
      for (int k = 0; k < PEAK - 1; k++) begin
        hist[k] <= hist[k+1];
        hocc[k] <= hocc[k+1];
      end
      hist[PEAK-1] <= val;
      hocc[PEAK-1] <= 1'b1;
    end
  end
endmodule

// File: rtl/scf_ctrl.sv
module scf_ctrl #(
  parameter int TYPE_W = 2,
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              above_th,
  input  logic              joins,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              peak_ok,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              start,
  output logic              accept,
  output logic              clr,
  output logic              emit,
  output logic              out_valid,
  output logic              active,
  output logic [TYPE_W-1:0] cl_type,
  output logic [ADDR_W-1:0] last_addr,
  output logic [CNT_W-1:0]  checked
);
  import scf_pkg::*;

  scf_state_e state;
  logic       scanning;
  logic       closing;

  assign scanning  = state == ST_SCAN;
  assign closing   = scanning && in_valid && active && !joins;
  assign in_ready  = scanning && !closing;
  assign start     = scanning && in_valid && !active && above_th;
  assign accept    = scanning && in_valid && joins;
  assign clr       = closing;
  assign emit      = closing && peak_ok;
  assign out_valid = state == ST_OUT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SCAN;
      active    <= 1'b0;
      cl_type   <= '0;
      last_addr <= '0;
      checked   <= '0;
    end else begin
      if (emit) state <= ST_OUT;
      else if (!scanning && out_ready) state <= ST_SCAN;

      if (start) begin
        active    <= 1'b1;
        cl_type   <= in_type;
        last_addr <= in_addr;
        checked   <= CNT_W'(1);
      end else if (accept) begin
        last_addr <= in_addr;
        if (checked != {CNT_W{1'b1}}) checked <= checked + 1'b1;
      end else if (closing) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/scf_cluster_finder.sv
module scf_cluster_finder #(
  parameter int VAL_W  = 8,
  parameter int TYPE_W = 2,
  parameter int ADDR_W = 11,
  parameter int SLOTS  = 5,
  parameter int CNT_W  = 8,
  localparam int USED_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [VAL_W-1:0]       th_join,
  input  logic [VAL_W-1:0]       th_peak,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_end,
  input  logic [VAL_W-1:0]       in_val,
  input  logic [TYPE_W-1:0]      in_type,
  input  logic [ADDR_W-1:0]      in_addr,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SLOTS*VAL_W-1:0] out_vals,
  output logic [ADDR_W-1:0]      out_addr,
  output logic                   out_five,
  output logic [USED_W-1:0]      out_used,
  output logic [CNT_W-1:0]       out_checked
);
  logic              above_th, joins, start, accept, clr, emit, active;
  logic [TYPE_W-1:0] cl_type;
  logic [ADDR_W-1:0] last_addr, peak_addr;
  logic [CNT_W-1:0]  checked;
  logic [VAL_W-1:0]  peak_val;
  logic [SLOTS*VAL_W-1:0] slot_flat;
  logic [SLOTS-1:0]  occ;

  scf_join_check #(.VAL_W(VAL_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_join (
    .active(active), .in_end(in_end), .in_val(in_val), .in_type(in_type),
    .in_addr(in_addr), .cl_type(cl_type), .last_addr(last_addr),
    .th_join(th_join), .above_th(above_th), .joins(joins)
  );

  scf_slots #(.VAL_W(VAL_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst(rst), .clr(clr), .start(start), .accept(accept),
    .val(in_val), .addr(in_addr), .peak_val(peak_val), .peak_addr(peak_addr),
    .slot_flat(slot_flat), .occ(occ)
  );

  scf_ctrl #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .above_th(above_th),
    .joins(joins), .in_type(in_type), .in_addr(in_addr),
    .peak_ok(peak_val >= th_peak), .out_ready(out_ready), .in_ready(in_ready),
    .start(start), .accept(accept), .clr(clr), .emit(emit),
    .out_valid(out_valid), .active(active), .cl_type(cl_type),
    .last_addr(last_addr), .checked(checked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vals    <= '0;
      out_addr    <= '0;
      out_five    <= 1'b0;
      out_used    <= '0;
      out_checked <= '0;
    end else if (emit) begin
      out_vals    <= slot_flat;
      out_addr    <= peak_addr - 1'b1;
      out_five    <= occ[0] && occ[SLOTS-1];
      out_used    <= USED_W'($countones(occ));
      out_checked <= checked;
    end
  end
endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
  parameter int VAL_W  = 8,
  parameter int ADDR_W = 11,
  parameter int SLOTS  = 5,
  parameter int CNT_W  = 8,
  parameter int USED_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [VAL_W-1:0]       th_peak,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [SLOTS*VAL_W-1:0] out_vals,
  input logic [ADDR_W-1:0]      out_addr,
  input logic                   out_five,
  input logic [USED_W-1:0]      out_used,
  input logic [CNT_W-1:0]       out_checked
);
  localparam int PEAK = SLOTS / 2;

  logic [VAL_W-1:0] pk;
  logic             order_ok;

  assign pk = out_vals[PEAK*VAL_W +: VAL_W];

  always_comb begin
    order_ok = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      if (k < PEAK && out_vals[k*VAL_W +: VAL_W] > pk) order_ok = 1'b0;
      if (k > PEAK && out_vals[k*VAL_W +: VAL_W] >= pk) order_ok = 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_vals) && $stable(out_addr)
      && $stable(out_five) && $stable(out_used) && $stable(out_checked));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_peak_thresh_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> pk >= $past(th_peak));

  p_peak_order_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> order_ok);

  p_five_full_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_five |-> out_used == USED_W'(SLOTS));

  p_counts_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_used != '0 && out_checked >= CNT_W'(out_used));
endmodule

bind scf_cluster_finder scf_checker #(
  .VAL_W(VAL_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS), .CNT_W(CNT_W), .USED_W(USED_W)
) u_chk (
  .clk(clk), .rst(rst), .th_peak(th_peak), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_vals(out_vals),
  .out_addr(out_addr), .out_five(out_five), .out_used(out_used),
  .out_checked(out_checked)
);

// File: tb/tb_scf_cluster_finder.sv
`timescale 1ns/1ps
module tb_scf_cluster_finder;
  localparam int VW = 8, TW = 2, AW = 11, SL = 5, CW = 8;
  localparam int UW = $clog2(SL + 1);
  localparam int PK = SL / 2;
  localparam int RW = SL*VW + AW + 1 + UW + CW;
  localparam int MAXW = 1024, MAXC = 512;

  logic clk = 1'b0, rst = 1'b1;
  logic [VW-1:0] th_join = '0, th_peak = '0;
  logic in_valid = 1'b0, in_end = 1'b0, in_ready;
  logic [VW-1:0] in_val = '0;
  logic [TW-1:0] in_type = '0;
  logic [AW-1:0] in_addr = '0;
  logic out_valid, out_ready, out_five;
  logic [SL*VW-1:0] out_vals;
  logic [AW-1:0] out_addr;
  logic [UW-1:0] out_used;
  logic [CW-1:0] out_checked;

  always #2.5 clk = ~clk;

  scf_cluster_finder dut (
    .clk(clk), .rst(rst), .th_join(th_join), .th_peak(th_peak),
    .in_valid(in_valid), .in_ready(in_ready), .in_end(in_end), .in_val(in_val),
    .in_type(in_type), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_vals(out_vals), .out_addr(out_addr),
    .out_five(out_five), .out_used(out_used), .out_checked(out_checked)
  );

  logic [VW-1:0] w_val [MAXW];
  logic [TW-1:0] w_typ [MAXW];
  logic [AW-1:0] w_adr [MAXW];
  logic          w_end [MAXW];
  int nw, taken;
  logic [RW-1:0] exp_r [MAXC];
  logic [RW-1:0] got_r [MAXC];
  int nexp, ngot;
  int total = 0, bad = 0;
  bit bp_en = 0, gaps = 0, done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, ex);
    end
  endtask

  task automatic add_word(input logic [VW-1:0] v, input logic [TW-1:0] t, input logic [AW-1:0] a, input logic e);
    w_val[nw] = v; w_typ[nw] = t; w_adr[nw] = a; w_end[nw] = e; nw++;
  endtask

  // Arithmetic model built from R1..R8
  task automatic run_model();
    bit act, above;
    logic [VW-1:0] d [SL];
    bit o [SL];
    logic [VW-1:0] h [PK];
    bit ho [PK];
    int fill, chkc, used, i;
    logic [AW-1:0] pa, la;
    logic [TW-1:0] ty;
    logic [SL*VW-1:0] pv;
    nexp = 0; act = 0; i = 0; fill = 0; chkc = 0; pa = '0; la = '0; ty = '0;
    for (int k = 0; k < SL; k++) begin d[k] = '0; o[k] = 0; end
    for (int k = 0; k < PK; k++) begin h[k] = '0; ho[k] = 0; end
    while (i < nw) begin
      above = !w_end[i] && (w_val[i] >= th_join);
      if (!act) begin
        if (above) begin
          for (int k = 0; k < SL; k++) begin d[k] = '0; o[k] = 0; end
          for (int k = 0; k < PK; k++) begin h[k] = '0; ho[k] = 0; end
          d[PK] = w_val[i]; o[PK] = 1; h[PK-1] = w_val[i]; ho[PK-1] = 1;
          fill = PK + 1; pa = w_adr[i]; la = w_adr[i]; ty = w_typ[i]; chkc = 1; act = 1;
        end
        i++;
      end else if (above && w_typ[i] == ty && w_adr[i] == AW'(la + 1)) begin
        if (w_val[i] >= d[PK]) begin
          for (int k = 0; k < PK; k++) begin d[k] = h[k]; o[k] = ho[k]; end
          d[PK] = w_val[i];
          for (int k = PK + 1; k < SL; k++) begin d[k] = '0; o[k] = 0; end
          fill = PK + 1; pa = w_adr[i];
        end else if (fill < SL) begin
          d[fill] = w_val[i]; o[fill] = 1; fill++;
        end
        for (int k = 0; k < PK - 1; k++) begin h[k] = h[k+1]; ho[k] = ho[k+1]; end
        h[PK-1] = w_val[i]; ho[PK-1] = 1;
        la = w_adr[i];
        if (chkc < (1 << CW) - 1) chkc++;
        i++;
      end else begin
        if (d[PK] >= th_peak) begin
          used = 0;
          for (int k = 0; k < SL; k++) begin pv[k*VW +: VW] = d[k]; used += int'(o[k]); end
          exp_r[nexp] = {pv, AW'(pa - 1), (o[0] && o[SL-1]) ? 1'b1 : 1'b0, UW'(used), CW'(chkc)};
          nexp++;
        end
        act = 0;
      end
    end
  endtask

  task automatic drive_all();
    taken = 0;
    for (int i = 0; i < nw; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_val = w_val[i]; in_type = w_typ[i]; in_addr = w_adr[i]; in_end = w_end[i];
      forever begin
        #1;
        if (in_ready) begin
          @(negedge clk);
          taken++;
          break;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_end = 1'b0;
  endtask

  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (!rst && out_valid && out_ready && ngot < MAXC) begin
        got_r[ngot] = {out_vals, out_addr, out_five, out_used, out_checked};
        ngot++;
      end
    end
  end

  task automatic run_scen(input string req);
    run_model();
    ngot = 0;
    drive_all();
    repeat (40) @(negedge clk);
    chk(taken == nw, req, 128'(taken), 128'(nw));
    chk(ngot == nexp, req, 128'(ngot), 128'(nexp));
    for (int k = 0; k < nexp && k < ngot; k++)
      chk(got_r[k] === exp_r[k], req, 128'(got_r[k]), 128'(exp_r[k]));
  endtask

  task automatic rand_stream(input int n);
    logic [AW-1:0] a;
    logic [TW-1:0] t;
    nw = 0; a = AW'($urandom); t = '0;
    for (int i = 0; i < n; i++) begin
      if ($urandom % 20 == 0) add_word('0, '0, '0, 1'b1);
      else begin
        if ($urandom % 10 == 0) a = AW'($urandom); else a = a + 1'b1;
        if ($urandom % 10 == 0) t = TW'($urandom);
        add_word(($urandom % 2) ? VW'($urandom % 48) : VW'($urandom), t, a, 1'b0);
      end
    end
    add_word('0, '0, '0, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11 out_valid", 128'(out_valid), 0);
    rst = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R11 in_ready", 128'(in_ready), 1);
    @(negedge clk);

    // R4: re-centring with shadow strips, closed by zero-valued strip
    th_join = 8'd5; th_peak = 8'd30; nw = 0;
    begin
      logic [VW-1:0] seq [11] = '{8'd10, 8'd20, 8'd40, 8'd30, 8'd20, 8'd15, 8'd12, 8'd50, 8'd25, 8'd18, 8'd0};
      for (int i = 0; i < 11; i++) add_word(seq[i], 2'd1, AW'(i + 2), 1'b0);
    end
    add_word('0, '0, '0, 1'b1);
    run_scen("R4");
    chk(ngot == 1 && got_r[0] === {8'd18, 8'd25, 8'd50, 8'd12, 8'd15, 11'd8, 1'b1, 3'd5, 8'd10},
        "R4 R12 R8 recentre", 128'(got_r[0]), 128'({8'd18, 8'd25, 8'd50, 8'd12, 8'd15, 11'd8, 1'b1, 3'd5, 8'd10}));

    // R3: falling strips fill slots 4,5 then only shadows
    nw = 0;
    add_word(8'd40, 0, 11'd100, 0); add_word(8'd30, 0, 11'd101, 0); add_word(8'd20, 0, 11'd102, 0);
    add_word(8'd10, 0, 11'd103, 0); add_word(8'd5, 0, 11'd104, 0); add_word('0, 0, 0, 1);
    run_scen("R3");
    chk(ngot == 1 && got_r[0] === {8'd0, 8'd0, 8'd40, 8'd30, 8'd20, 11'd99, 1'b0, 3'd3, 8'd5} ? 1'b0 : 1'b1, "R3 slot order unused", 0, 0);
    chk(ngot == 1 && got_r[0] === {8'd20, 8'd30, 8'd40, 8'd0, 8'd0, 11'd99, 1'b0, 3'd3, 8'd5},
        "R2 R3 fill", 128'(got_r[0]), 128'({8'd20, 8'd30, 8'd40, 8'd0, 8'd0, 11'd99, 1'b0, 3'd3, 8'd5}));

    // R5: peak under th_peak dropped
    nw = 0;
    add_word(8'd10, 0, 11'd5, 0); add_word(8'd12, 0, 11'd6, 0); add_word('0, 0, 0, 1);
    run_scen("R5");
    chk(ngot == 0, "R5 dropped", 128'(ngot), 0);

    // R10: sub-threshold words and markers with nothing open
    nw = 0;
    add_word(8'd3, 0, 11'd1, 0); add_word(8'd2, 0, 11'd2, 0); add_word('0, 0, 0, 1); add_word(8'd4, 0, 11'd3, 0);
    run_scen("R10");
    chk(ngot == 0 && taken == 4, "R10 discarded", 128'(taken), 4);

    // R6: terminator of one cluster starts the next (type change)
    nw = 0;
    add_word(8'd40, 0, 11'd10, 0); add_word(8'd20, 0, 11'd11, 0);
    add_word(8'd50, 1, 11'd12, 0); add_word(8'd60, 1, 11'd13, 0); add_word('0, 0, 0, 1);
    run_scen("R6");
    chk(ngot == 2 && got_r[1] === {8'd0, 8'd0, 8'd60, 8'd50, 8'd0, 11'd12, 1'b0, 3'd2, 8'd2},
        "R6 R1 restart", 128'(got_r[1]), 128'({8'd0, 8'd0, 8'd60, 8'd50, 8'd0, 11'd12, 1'b0, 3'd2, 8'd2}));

    // R1: address gap splits
    nw = 0;
    add_word(8'd40, 0, 11'd20, 0); add_word(8'd50, 0, 11'd22, 0); add_word('0, 0, 0, 1);
    run_scen("R1");
    chk(ngot == 2, "R1 gap split", 128'(ngot), 2);

    // R7: address wrap
    nw = 0;
    add_word(8'd6, 2, 11'd2046, 0); add_word(8'd7, 2, 11'd2047, 0); add_word(8'd40, 2, 11'd0, 0); add_word('0, 0, 0, 1);
    run_scen("R7");
    chk(ngot == 1 && got_r[0][CW+UW+1 +: AW] == 11'd2047, "R7 wrap", 128'(got_r[0][CW+UW+1 +: AW]), 2047);

    // R8: checked counter saturates
    nw = 0;
    for (int i = 0; i < 300; i++) add_word(8'd100, 0, AW'(i + 500), 0);
    add_word('0, 0, 0, 1);
    run_scen("R8");
    chk(ngot == 1 && got_r[0][CW-1:0] == 8'd255 && got_r[0][CW +: UW] == 3'd3, "R8 saturate",
        128'(got_r[0][CW+UW-1:0]), 128'({3'd3, 8'd255}));

    // R9 R1..R8 sweeps over thresholds, back-pressure and input gaps
    for (int c = 0; c < 8; c++) begin
      bp_en = c[0]; gaps = c[1];
      th_join = (c[2]) ? 8'd20 : 8'd1;
      th_peak = (c[2]) ? 8'd100 : 8'd30;
      rand_stream(250);
      run_scen("R9 sweep");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule